// File: doc/BRIEF.md
# Sample Pipeline with Clamp Control

This block is the digital back end of an image-sensor sample path. Raw 10-bit converter words arrive together with a sample strobe; every accepted word travels through a fixed nine-stage delay line and leaves on a registered output bus. A valid flag moves along the delay line with the data, so downstream logic knows when the line has filled for the first time after reset. An output-mode field can switch the bus output enable off. The data path keeps moving while the enable is off, so the bus carries current data again as soon as the enable returns.

The block also takes three externally timed pulses: an optical-black clamp, a dummy clamp and a pixel-blanking pulse. Each arrives in either polarity, and a 2-bit clock-mode field normalises it. The block turns these pulses into internal clamp and blank enables. The dummy clamp wins over blanking. An optical-black pulse counts only after it has lasted a minimum number of cycles. A shorter pulse is dropped and sets a sticky flag. While blanking wins, the word entering the delay line is replaced by a configured black-level code.

All configuration inputs are static fields held by a separate register block.

Top module: `pix_backend`

## Requirements
- R1: With the sample strobe active on every cycle, a word accepted at one rising edge appears on `dout` after the ninth accepting edge, counting its own edge. In general, after N accepts `dout` holds accepted word N-9 (counting from 0) when N is at least 9, and 0 before that.
- R2: A word is accepted only on a rising edge where the normalised sample strobe is high. On any other edge, `dout` and `dout_vld` keep their values.
- R3: In `cfg_clk_mode`, bit 1 set means the sample strobe is active high and bit 1 clear means active low. Bit 0 does the same for the three clamp/blank pulses. So 00 is both active low, 01 is strobe low with clamps high, 10 is strobe high with clamps low, and 11 is both active high.
- R4: `dout_oe` is a register. It goes low on the edge after `cfg_out_mode` reads 01 and is high for every other code. The delay line keeps accepting words while the output is disabled.
- R5: `dm_clamp_en` is the normalised dummy-clamp pulse, registered for one cycle. `blank_en` is the normalised blanking pulse ANDed with the inverse of the normalised dummy clamp, registered for one cycle. The two are never high together.
- R6: A word accepted while normalised blanking is high and the normalised dummy clamp is low enters the delay line as `cfg_black` in place of `smp_data`.
- R7: `ob_clamp_en` rises on the edge at which the normalised optical-black pulse has been high for 10 consecutive sampled cycles. It stays high while the pulse stays high and drops on the edge that samples the pulse low.
- R8: An optical-black pulse that ends after 1 to 9 high cycles never raises `ob_clamp_en`. It sets `ob_short` on the edge that samples the pulse low, and `ob_short` stays set until reset.
- R9: `dout_vld` is low until the ninth word accepted since reset reaches `dout`, and stays high afterwards.
- R10: After a synchronous reset, `dout` is 0, `dout_oe` is 1, and `dout_vld`, `ob_clamp_en`, `dm_clamp_en`, `blank_en` and `ob_short` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_clk_mode | input | 2 | Polarity field: bit 1 sample strobe, bit 0 clamp/blank pulses (1 = active high) |
| cfg_out_mode | input | 2 | Output mode: 01 disables the bus, other codes drive it |
| cfg_black | input | 10 | Black-level code substituted during blanking |
| smp_strobe | input | 1 | Sample strobe, raw polarity |
| smp_data | input | 10 | Converter word |
| ob_pulse | input | 1 | Optical-black clamp pulse, raw polarity |
| dm_pulse | input | 1 | Dummy clamp pulse, raw polarity |
| blk_pulse | input | 1 | Pixel blanking pulse, raw polarity |
| dout | output | 10 | Delayed sample |
| dout_oe | output | 1 | Output enable for the data bus |
| dout_vld | output | 1 | Delay line filled since reset |
| ob_clamp_en | output | 1 | Qualified optical-black clamp enable |
| dm_clamp_en | output | 1 | Dummy clamp enable |
| blank_en | output | 1 | Blank enable after dummy-clamp priority |
| ob_short | output | 1 | Sticky flag for a too-short optical-black pulse |

## Verification
Some rules are checked on every cycle. These are the one-cycle rules: the dummy clamp excluding blanking, the dummy-clamp enable following its pulse, the output enable following the mode field, the output holding while the strobe is idle, the clamp enable dropping when its pulse ends, and the flags staying set once raised. Other behaviour shows only in the bench scenarios, because it needs a long history: the exact nine-accept delay of each word, the black-code substitution, the ten-cycle qualification of the optical-black pulse, and the first point at which the valid flag rises. The bench applies all four polarity codes and includes pulses of exactly 9 and 10 cycles.

// File: rtl/pix_backend_pkg.sv
package pix_backend_pkg;
  localparam int unsigned SMP_W = 10;
  localparam int unsigned PIPE_LAT = 9;
  localparam int unsigned OB_MIN_CYC = 10;

  typedef enum logic [1:0] {
    OUTM_DRIVE = 2'b00,
    OUTM_HIZ   = 2'b01,
    OUTM_RSV2  = 2'b10,
    OUTM_RSV3  = 2'b11
  } out_mode_e;

  typedef struct packed {
    logic smp;
    logic ob;
    logic dm;
    logic blk;
  } pulse_set_t;
endpackage

// File: rtl/pbe_polarity.sv
module pbe_polarity #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] raw,
  input  logic [N-1:0] act_high,
  output logic [N-1:0] norm
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign norm[i] = act_high[i] ? raw[i] : ~raw[i];
  end
endmodule

// File: rtl/pbe_ob_qual.sv
module pbe_ob_qual #(
  parameter int unsigned MIN_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic ob_n,
  output logic ob_en,
  output logic short_flag
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_CYC);
  localparam logic [CW-1:0] CQUAL = CW'(MIN_CYC - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt    <= '0;
      ob_en      <= 1'b0;
      short_flag <= 1'b0;
    end else begin
      if (ob_n) begin
        if (run_cnt != CMAX) run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= '0;
      end
      ob_en <= ob_n && (run_cnt >= CQUAL);
      if (!ob_n && (run_cnt != '0) && (run_cnt < CMAX)) short_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/pbe_delay.sv
module pbe_delay #(
  parameter int unsigned DW  = 10,
  parameter int unsigned LAT = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          vld
);
  logic [DW-1:0] stg [LAT];
  logic [LAT-1:0] vstg;

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          stg[0]  <= '0;
          vstg[0] <= 1'b0;
        end else if (adv) begin
          stg[0]  <= din;
          vstg[0] <= 1'b1;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          stg[i]  <= '0;
          vstg[i] <= 1'b0;
        end else if (adv) begin
          stg[i]  <= stg[i-1];
          vstg[i] <= vstg[i-1];
        end
      end
    end
  end

  assign dout = stg[LAT-1];
  assign vld  = vstg[LAT-1];
endmodule

// File: rtl/pix_backend.sv
module pix_backend
  import pix_backend_pkg::*;
#(
  parameter int unsigned DW      = SMP_W,
  parameter int unsigned LAT     = PIPE_LAT,
  parameter int unsigned OB_MIN  = OB_MIN_CYC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_clk_mode,
  input  logic [1:0]    cfg_out_mode,
  input  logic [DW-1:0] cfg_black,
  input  logic          smp_strobe,
  input  logic [DW-1:0] smp_data,
  input  logic          ob_pulse,
  input  logic          dm_pulse,
  input  logic          blk_pulse,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          dout_vld,
  output logic          ob_clamp_en,
  output logic          dm_clamp_en,
  output logic          blank_en,
  output logic          ob_short
);
  localparam int unsigned NP = $bits(pulse_set_t);

  pulse_set_t raw_p, act_p, nrm_p;
  logic [DW-1:0] fill_word;
  logic          blank_wins;

  assign raw_p = '{smp: smp_strobe, ob: ob_pulse, dm: dm_pulse, blk: blk_pulse};
  assign act_p = '{smp: cfg_clk_mode[1], ob: cfg_clk_mode[0],
                   dm: cfg_clk_mode[0], blk: cfg_clk_mode[0]};

  pbe_polarity #(.N(NP)) u_pol (
    .raw      (raw_p),
    .act_high (act_p),
    .norm     (nrm_p)
  );

  assign blank_wins = nrm_p.blk & ~nrm_p.dm;
  assign fill_word  = blank_wins ? cfg_black : smp_data;

  pbe_delay #(.DW(DW), .LAT(LAT)) u_dly (
    .clk  (clk),
    .rst  (rst),
    .adv  (nrm_p.smp),
    .din  (fill_word),
    .dout (dout),
    .vld  (dout_vld)
  );

  pbe_ob_qual #(.MIN_CYC(OB_MIN)) u_obq (
    .clk        (clk),
    .rst        (rst),
    .ob_n       (nrm_p.ob),
    .ob_en      (ob_clamp_en),
    .short_flag (ob_short)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_oe     <= 1'b1;
      dm_clamp_en <= 1'b0;
      blank_en    <= 1'b0;
    end else begin
      dout_oe     <= (out_mode_e'(cfg_out_mode) != OUTM_HIZ);
      dm_clamp_en <= nrm_p.dm;
      blank_en    <= blank_wins;
    end
  end
endmodule

// File: rtl/pix_backend_chk.sv
module pix_backend_chk #(
  parameter int unsigned DW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cfg_clk_mode,
  input logic [1:0]    cfg_out_mode,
  input logic          smp_strobe,
  input logic          ob_pulse,
  input logic          dm_pulse,
  input logic [DW-1:0] dout,
  input logic          dout_oe,
  input logic          dout_vld,
  input logic          ob_clamp_en,
  input logic          dm_clamp_en,
  input logic          blank_en,
  input logic          ob_short
);
  a_r5_excl: assert property (@(posedge clk) disable iff (rst)
    !(blank_en && dm_clamp_en));
  a_r5_dm_follow: assert property (@(posedge clk) disable iff (rst)
    (dm_pulse == cfg_clk_mode[0]) |=> dm_clamp_en);
  a_r4_hiz: assert property (@(posedge clk) disable iff (rst)
    (cfg_out_mode == 2'b01) |=> !dout_oe);
  a_r4_drive: assert property (@(posedge clk) disable iff (rst)
    (cfg_out_mode != 2'b01) |=> dout_oe);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (smp_strobe != cfg_clk_mode[1]) |=> ($stable(dout) && $stable(dout_vld)));
  a_r7_drop: assert property (@(posedge clk) disable iff (rst)
    (ob_pulse != cfg_clk_mode[0]) |=> !ob_clamp_en);
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    ob_short |=> ob_short);
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    dout_vld |=> dout_vld);
endmodule

bind pix_backend pix_backend_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cfg_clk_mode(cfg_clk_mode), .cfg_out_mode(cfg_out_mode),
  .smp_strobe(smp_strobe), .ob_pulse(ob_pulse), .dm_pulse(dm_pulse),
  .dout(dout), .dout_oe(dout_oe), .dout_vld(dout_vld), .ob_clamp_en(ob_clamp_en),
  .dm_clamp_en(dm_clamp_en), .blank_en(blank_en), .ob_short(ob_short)
);

// File: tb/pix_backend_tb.sv
module pix_backend_tb;
  localparam int DW = 10;
  localparam int LAT = 9;
  localparam int OBMIN = 10;
  localparam int HMAX = 4096;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] cfg_clk_mode, cfg_out_mode;
  logic [DW-1:0] cfg_black, smp_data;
  logic smp_strobe, ob_pulse, dm_pulse, blk_pulse;
  logic [DW-1:0] dout;
  logic dout_oe, dout_vld, ob_clamp_en, dm_clamp_en, blank_en, ob_short;

  always #4 clk = ~clk;

  pix_backend u_dut (
    .clk(clk), .rst(rst), .cfg_clk_mode(cfg_clk_mode), .cfg_out_mode(cfg_out_mode),
    .cfg_black(cfg_black), .smp_strobe(smp_strobe), .smp_data(smp_data),
    .ob_pulse(ob_pulse), .dm_pulse(dm_pulse), .blk_pulse(blk_pulse),
    .dout(dout), .dout_oe(dout_oe), .dout_vld(dout_vld), .ob_clamp_en(ob_clamp_en),
    .dm_clamp_en(dm_clamp_en), .blank_en(blank_en), .ob_short(ob_short)
  );

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] hist [HMAX];
  int acc = 0;
  int ob_cnt = 0;
  logic e_oe = 1'b1, e_dm = 1'b0, e_blk = 1'b0, e_ob = 1'b0, e_short = 1'b0;
  logic l_smp, l_ob, l_dm, l_blk;

  function automatic logic to_raw(input logic lvl, input logic act_high);
    return act_high ? lvl : ~lvl;
  endfunction

  function automatic logic [DW-1:0] exp_dout(input int n);
    return (n >= LAT) ? hist[(n - LAT) % HMAX] : '0;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive logical levels; raw pins follow cfg_clk_mode polarity (R3)
  task automatic drive(input logic s, input logic o, input logic d, input logic b,
                       input logic [DW-1:0] data);
    l_smp = s; l_ob = o; l_dm = d; l_blk = b;
    smp_strobe = to_raw(s, cfg_clk_mode[1]);
    ob_pulse   = to_raw(o, cfg_clk_mode[0]);
    dm_pulse   = to_raw(d, cfg_clk_mode[0]);
    blk_pulse  = to_raw(b, cfg_clk_mode[0]);
    smp_data   = data;
  endtask

  // one clock: update model at the edge, compare at the next falling edge
  task automatic step();
    @(posedge clk);
    e_oe  = (cfg_out_mode != 2'b01);
    e_dm  = l_dm;
    e_blk = l_blk & ~l_dm;
    if (l_smp) begin
      hist[acc % HMAX] = (l_blk && !l_dm) ? cfg_black : smp_data;
      acc++;
    end
    e_ob = l_ob && (ob_cnt >= OBMIN - 1);
    if (!l_ob && ob_cnt != 0 && ob_cnt < OBMIN) e_short = 1'b1;
    ob_cnt = l_ob ? ((ob_cnt < OBMIN) ? ob_cnt + 1 : OBMIN) : 0;
    @(negedge clk);
    check("R1/R2/R6 dout", dout, exp_dout(acc));
    check("R9 vld", DW'(dout_vld), DW'(acc >= LAT));
    check("R4 oe", DW'(dout_oe), DW'(e_oe));
    check("R5 dm", DW'(dm_clamp_en), DW'(e_dm));
    check("R5 blank", DW'(blank_en), DW'(e_blk));
    check("R7 ob_en", DW'(ob_clamp_en), DW'(e_ob));
    check("R8 short", DW'(ob_short), DW'(e_short));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfg_clk_mode = 2'b11; cfg_out_mode = 2'b00; cfg_black = 10'h040;
    drive(0, 0, 0, 0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10 dout", dout, '0);
    check("R10 oe", DW'(dout_oe), DW'(1));
    check("R10 flags", DW'({dout_vld, ob_clamp_en, dm_clamp_en, blank_en, ob_short}), '0);
    rst = 1'b0;

    // R1 continuous strobe, R9 first valid after ninth accept
    for (int i = 0; i < 12; i++) begin
      drive(1, 0, 0, 0, DW'(i + 16'h101));
      step();
    end
    // R2 stalls hold output
    for (int i = 0; i < 5; i++) begin
      drive(0, 0, 0, 0, 10'h3FF);
      step();
    end
    // R7 pulse of exactly 10 qualifies, R8 pulse of 9 sets flag
    for (int i = 0; i < 10; i++) begin drive(1, 1, 0, 0, DW'(i)); step(); end
    check("R7 qualified at 10", DW'(ob_clamp_en), DW'(1));
    drive(1, 0, 0, 0, 10'h0AA); step();
    check("R8 no flag after 10", DW'(ob_short), DW'(0));
    for (int i = 0; i < 9; i++) begin drive(1, 1, 0, 0, DW'(i)); step(); end
    check("R8 no enable at 9", DW'(ob_clamp_en), DW'(0));
    drive(1, 0, 0, 0, 10'h0BB); step();
    check("R8 flag set", DW'(ob_short), DW'(1));

    // R5 both pulses: dummy clamp wins; R6 blanking alone substitutes black
    drive(1, 0, 1, 1, 10'h155); step();
    drive(1, 0, 0, 1, 10'h2AA); step();

    // R4 output disabled while pipeline advances
    cfg_out_mode = 2'b01;
    for (int i = 0; i < 6; i++) begin drive(1, 0, 0, 0, DW'(i + 10'h200)); step(); end
    cfg_out_mode = 2'b10;
    drive(1, 0, 0, 0, 10'h321); step();

    // R3 all polarity codes with random traffic
    for (int m = 0; m < 8; m++) begin
      cfg_clk_mode = 2'(m);
      cfg_out_mode = 2'($urandom_range(0, 3));
      cfg_black = DW'($urandom);
      for (int i = 0; i < 200; i++) begin
        logic ob_lvl;
        ob_lvl = ($urandom_range(0, 15) < 2) ? ~l_ob : l_ob;
        drive(1'($urandom_range(0, 3) != 0), ob_lvl, 1'($urandom_range(0, 5) == 0),
              1'($urandom_range(0, 3) == 0), DW'($urandom));
        step();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule